// File: doc/BRIEF.md
# Banked Rotate and Set Executor

This block is one execution slice of an 8-bit accumulator-style core. Each instruction cycle it takes a 16-bit instruction word and steps it through four fixed phases: decode, operand read, process and write-back. It recognises two instructions and treats every other word as a no-op. The first rotates a data-memory byte one place right without using a carry. The second fills a data-memory byte with all ones.

The slice holds the working register, a bank select register, the negative and zero flags and a banked data memory. Operands are reached in one of two ways. In direct mode the 8-bit field lands in the bottom half of bank 0 or the top half of the highest bank. In banked mode the bank select register supplies the upper address bits. Only part of the 12-bit data space is modelled, and the address decode still holds for it.

A test port loads and reads the memory, and loads the working and bank select registers, so a bench can set up operands and observe results.

Top module: `bank_rot_exec`

## Requirements
- R1: An active-high synchronous reset clears the working register, the bank select register and both flags, and returns the phase output to 0 (decode).
- R2: The phase output steps 0, 1, 2, 3 and back to 0 on successive clocks. The instruction word is latched at the edge that ends phase 0. Its result is visible after the edge that ends phase 3.
- R3: A rotate word has bits 15:10 = 010000, destination bit 9, mode bit 8 and field bits 7:0. Its result moves operand bit n to bit n-1 and operand bit 0 to bit 7; for example 0xD7 gives 0xEB.
- R4: A rotate with bit 9 = 0 writes its result to the working register and leaves memory unchanged. With bit 9 = 1 it writes the result back to the addressed byte and leaves the working register unchanged.
- R5: A set word has bits 15:9 = 0110100, mode bit 8 and field bits 7:0. It writes 0xFF to the addressed byte and leaves the working register unchanged.
- R6: After a rotate, the negative flag equals result bit 7 and the zero flag is 1 exactly when the result is 0. A set leaves both flags unchanged.
- R7: With mode bit 8 = 0, fields 0x00..0x7F address bank 0 and fields 0x80..0xFF address the highest bank, whatever the bank select register holds.
- R8: With mode bit 8 = 1, the address is the bank select register concatenated above the field.
- R9: Any word that is neither a rotate nor a set changes nothing: not the working register, not the flags, not the memory.
- R10: Only banks below LOW_BANKS and the highest bank are stored. Reads from any other bank return 0, and writes to them are dropped.
- R11: The test port writes memory at tp_addr when tp_we is high and reads memory combinationally on tp_rdata. It loads the working register from tp_wdata when tp_w_we is high, and the bank select register from the low tp_wdata bits when tp_bsr_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word, latched at the end of phase 0 |
| phase_o | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |
| w_o | output | 8 | Working register |
| bsr_o | output | BANK_W | Bank select register |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| tp_we | input | 1 | Test-port memory write enable |
| tp_addr | input | BANK_W+8 | Test-port memory address |
| tp_wdata | input | 8 | Test-port write data for memory, working and bank registers |
| tp_rdata | output | 8 | Test-port memory read data |
| tp_w_we | input | 1 | Load working register from tp_wdata |
| tp_bsr_we | input | 1 | Load bank select register from tp_wdata |

## Verification
The bench builds the block with BANK_W = 4 and LOW_BANKS = 2. Only banks 0, 1 and 15 are stored, so the split decode path is used and unmodelled banks 2 to 14 can be reached. This small configuration allows several exhaustive sweeps: all 256 operand values for rotates to each destination, all 256 field values for set in each addressing mode, all 16 bank select values, and all 256 upper instruction bytes for the no-op rule. Each result is checked against a value the bench computes by arithmetic.

// File: rtl/brx_pkg.sv
package brx_pkg;
   localparam int DATA_W  = 8;
   localparam int F_W     = 8;
   localparam int INSTR_W = 16;

   typedef enum logic [1:0] {
      PH_DECODE = 2'd0,
      PH_READ   = 2'd1,
      PH_PROC   = 2'd2,
      PH_WRITE  = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_ROTR   = 2'd1,
      OP_SETALL = 2'd2
   } op_t;

   typedef struct packed {
      op_t            op;
      logic           to_file;
      logic           banked;
      logic [F_W-1:0] f;
   } dec_t;

   localparam logic [5:0] ROTR_KEY = 6'b010000;
   localparam logic [6:0] SET_KEY  = 7'b0110100;
endpackage

// File: rtl/brx_seq.sv
module brx_seq
   import brx_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   output phase_t phase
);
   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_DECODE;
      end else begin
         unique case (phase)
            PH_DECODE: phase <= PH_READ;
            PH_READ:   phase <= PH_PROC;
            PH_PROC:   phase <= PH_WRITE;
            default:   phase <= PH_DECODE;
         endcase
      end
   end
endmodule

// File: rtl/brx_decode.sv
module brx_decode
   import brx_pkg::*;
(
   input  logic [INSTR_W-1:0] ir,
   output dec_t               dec
);
   always_comb begin
      dec.f       = ir[F_W-1:0];
      dec.banked  = ir[8];
      dec.to_file = 1'b0;
      dec.op      = OP_NONE;
      if (ir[15:10] == ROTR_KEY) begin
         dec.op      = OP_ROTR;
         dec.to_file = ir[9];
      end else if (ir[15:9] == SET_KEY) begin
         dec.op      = OP_SETALL;
         dec.to_file = 1'b1;
      end
   end
endmodule

// File: rtl/brx_regfile.sv
module brx_regfile
   import brx_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int LOW_BANKS = 4,
   localparam int ADDR_W   = BANK_W + F_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_x,
   output logic [DATA_W-1:0] rdata_x,
   input  logic [ADDR_W-1:0] raddr_t,
   output logic [DATA_W-1:0] rdata_t
);
   localparam int NUM_BANKS = 1 << BANK_W;
   localparam bit SPLIT     = LOW_BANKS < NUM_BANKS;
   localparam int SLOTS     = SPLIT ? LOW_BANKS + 1 : LOW_BANKS;
   localparam int SLOT_W    = $clog2(SLOTS);
   localparam int IDX_W     = SLOT_W + F_W;
   localparam int DEPTH     = SLOTS << F_W;
   localparam logic [BANK_W-1:0] TOP_BANK = '1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] port_addr [3];
   logic [2:0]        hit;
   logic [IDX_W-1:0]  idx [3];

   assign port_addr[0] = waddr;
   assign port_addr[1] = raddr_x;
   assign port_addr[2] = raddr_t;

   for (genvar p = 0; p < 3; p++) begin : g_map
      if (SPLIT) begin : g_split
         logic [BANK_W-1:0] bank;
         logic [BANK_W-1:0] slot;
         assign bank   = port_addr[p][ADDR_W-1:F_W];
         assign hit[p] = (bank < BANK_W'(LOW_BANKS)) || (bank == TOP_BANK);
         assign slot   = (bank == TOP_BANK) ? BANK_W'(LOW_BANKS) : bank;
         assign idx[p] = {slot[SLOT_W-1:0], port_addr[p][F_W-1:0]};
      end else begin : g_full
         assign hit[p] = 1'b1;
         assign idx[p] = port_addr[p];
      end
   end

   always_ff @(posedge clk) begin
      if (we && hit[0]) mem[idx[0]] <= wdata;
   end

   assign rdata_x = hit[1] ? mem[idx[1]] : '0;
   assign rdata_t = hit[2] ? mem[idx[2]] : '0;
endmodule

// File: rtl/bank_rot_exec.sv
module bank_rot_exec
   import brx_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int LOW_BANKS = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [15:0]             instr,
   output logic [1:0]              phase_o,
   output logic [7:0]              w_o,
   output logic [BANK_W-1:0]       bsr_o,
   output logic                    flag_n_o,
   output logic                    flag_z_o,
   input  logic                    tp_we,
   input  logic [BANK_W+7:0]       tp_addr,
   input  logic [7:0]              tp_wdata,
   output logic [7:0]              tp_rdata,
   input  logic                    tp_w_we,
   input  logic                    tp_bsr_we
);
   localparam int ADDR_W = BANK_W + F_W;
   localparam logic [BANK_W-1:0] ACC_HI = '1;
   localparam logic [BANK_W-1:0] ACC_LO = '0;

   if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank_w
      $error("bank_rot_exec: BANK_W must lie in 1..8");
   end
   if (LOW_BANKS < 1 || LOW_BANKS > (1 << BANK_W)) begin : g_bad_low_banks
      $error("bank_rot_exec: LOW_BANKS must lie in 1..2**BANK_W");
   end

   phase_t              phase;
   dec_t                dec;
   logic [INSTR_W-1:0]  ir_q;
   logic [DATA_W-1:0]   opnd_q, res_q, rot, rd_x;
   logic [DATA_W-1:0]   w_q;
   logic [BANK_W-1:0]   bsr_q;
   logic                n_q, z_q;
   logic [ADDR_W-1:0]   eff_addr, mem_waddr;
   logic [DATA_W-1:0]   mem_wdata;
   logic                exec_we, mem_we;
   op_t                 cur_op;
   logic                cur_to_file;

   brx_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

   brx_decode u_dec (.ir(ir_q), .dec(dec));

   assign cur_op      = dec.op;
   assign cur_to_file = dec.to_file;

   always_comb begin
      if (dec.banked)     eff_addr = {bsr_q, dec.f};
      else if (dec.f[7])  eff_addr = {ACC_HI, dec.f};
      else                eff_addr = {ACC_LO, dec.f};
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_rot
      assign rot[b] = opnd_q[(b + 1) % DATA_W];
   end

   assign exec_we   = (phase == PH_WRITE) &&
                      ((dec.op == OP_SETALL) || (dec.op == OP_ROTR && dec.to_file));
   assign mem_we    = exec_we || tp_we;
   assign mem_waddr = exec_we ? eff_addr : tp_addr;
   assign mem_wdata = exec_we ? res_q : tp_wdata;

   brx_regfile #(.BANK_W(BANK_W), .LOW_BANKS(LOW_BANKS)) u_rf (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (mem_waddr),
      .wdata   (mem_wdata),
      .raddr_x (eff_addr),
      .rdata_x (rd_x),
      .raddr_t (tp_addr),
      .rdata_t (tp_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q   <= '0;
         opnd_q <= '0;
         res_q  <= '0;
      end else begin
         if (phase == PH_DECODE) ir_q   <= instr;
         if (phase == PH_READ)   opnd_q <= rd_x;
         if (phase == PH_PROC) begin
            unique case (dec.op)
               OP_ROTR:   res_q <= rot;
               OP_SETALL: res_q <= '1;
               default:   res_q <= opnd_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q   <= '0;
         bsr_q <= '0;
         n_q   <= 1'b0;
         z_q   <= 1'b0;
      end else begin
         if (phase == PH_WRITE && dec.op == OP_ROTR && !dec.to_file) w_q <= res_q;
         else if (tp_w_we)                                           w_q <= tp_wdata;
         if (tp_bsr_we) bsr_q <= tp_wdata[BANK_W-1:0];
         if (phase == PH_WRITE && dec.op == OP_ROTR) begin
            n_q <= res_q[DATA_W-1];
            z_q <= (res_q == '0);
         end
      end
   end

   assign phase_o  = phase;
   assign w_o      = w_q;
   assign bsr_o    = bsr_q;
   assign flag_n_o = n_q;
   assign flag_z_o = z_q;
endmodule

// File: rtl/brx_checker.sv
module brx_checker
   import brx_pkg::*;
#(
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        phase,
   input op_t               op,
   input logic              to_file,
   input logic [7:0]        w,
   input logic [BANK_W-1:0] bsr,
   input logic              n,
   input logic              z,
   input logic [7:0]        res,
   input logic              tp_w_we
);
   logic rst_q = 1'b0;
   always @(posedge clk) rst_q <= rst;

   always @(negedge clk) begin
      if (rst_q) begin
         p_reset_state_r1: assert (phase == 2'd0 && w == 8'h00 && bsr == '0 && !n && !z)
            else $error("reset state wrong");
      end
   end

   p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      phase == 2'd3 |=> phase == 2'd0);

   p_start_r2: assert property (@(posedge clk) disable iff (rst)
      phase == 2'd0 |=> phase == 2'd1);

   p_w_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (phase != 2'd3 && !tp_w_we) |=> $stable(w));

   p_w_file_dest_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && op == OP_ROTR && to_file && !tp_w_we) |=> $stable(w));

   p_set_keeps_w_r5: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && op == OP_SETALL && !tp_w_we) |=> $stable(w));

   p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(phase == 2'd3 && op == OP_ROTR) |=> $stable({n, z}));

   p_flag_vals_r6: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && op == OP_ROTR) |=> (n == $past(res[7]) && z == ($past(res) == 8'h00)));

   p_nop_r9: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && op == OP_NONE && !tp_w_we) |=> ($stable(w) && $stable({n, z})));
endmodule

bind bank_rot_exec brx_checker #(.BANK_W(BANK_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .phase   (phase_o),
   .op      (cur_op),
   .to_file (cur_to_file),
   .w       (w_o),
   .bsr     (bsr_o),
   .n       (flag_n_o),
   .z       (flag_z_o),
   .res     (res_q),
   .tp_w_we (tp_w_we)
);

// File: tb/bank_rot_exec_test.sv
module bank_rot_exec_test;
   localparam int BW = 4;
   localparam int LB = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = 16'h0000;
   logic [1:0]  phase_o;
   logic [7:0]  w_o;
   logic [3:0]  bsr_o;
   logic        flag_n_o, flag_z_o;
   logic        tp_we = 1'b0;
   logic [11:0] tp_addr = 12'h000;
   logic [7:0]  tp_wdata = 8'h00;
   logic [7:0]  tp_rdata;
   logic        tp_w_we = 1'b0;
   logic        tp_bsr_we = 1'b0;

   int checks = 0;
   int errors = 0;
   bit timed_out = 1'b0;

   always #10 clk = ~clk;

   bank_rot_exec #(.BANK_W(BW), .LOW_BANKS(LB)) uut (
      .clk(clk), .rst(rst), .instr(instr), .phase_o(phase_o), .w_o(w_o),
      .bsr_o(bsr_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
      .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata),
      .tp_w_we(tp_w_we), .tp_bsr_we(tp_bsr_we)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rotr(input logic [7:0] v);
      return {v[0], v[7:1]};
   endfunction

   function automatic bit stored(input logic [11:0] a);
      return (a[11:8] < 4'(LB)) || (a[11:8] == 4'hF);
   endfunction

   task automatic mem_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      tp_addr = a; tp_wdata = d; tp_we = 1'b1;
      @(negedge clk);
      tp_we = 1'b0;
   endtask

   task automatic mem_rd(input logic [11:0] a, output logic [7:0] d);
      @(negedge clk);
      tp_addr = a;
      #1 d = tp_rdata;
   endtask

   task automatic load_w(input logic [7:0] d);
      @(negedge clk);
      tp_wdata = d; tp_w_we = 1'b1;
      @(negedge clk);
      tp_w_we = 1'b0;
   endtask

   task automatic load_bsr(input logic [3:0] d);
      @(negedge clk);
      tp_wdata = {4'h0, d}; tp_bsr_we = 1'b1;
      @(negedge clk);
      tp_bsr_we = 1'b0;
   endtask

   task automatic exec(input logic [15:0] word);
      @(negedge clk);
      while (phase_o != 2'd0) @(negedge clk);
      instr = word;
      repeat (4) @(posedge clk);
      @(negedge clk);
      instr = 16'h0000;
   endtask

   task automatic run_all();
      logic [7:0]  rd, r;
      logic        n0, z0;
      logic [11:0] ea, alias_a;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 w", {8'h0, w_o}, 16'h0);
      check("R1 bsr", {12'h0, bsr_o}, 16'h0);
      check("R1 flags", {14'h0, flag_n_o, flag_z_o}, 16'h0);
      check("R1 phase", {14'h0, phase_o}, 16'h0);

      // R2: phase stepping
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         check("R2 phase", {14'h0, phase_o}, 16'(k % 4));
      end

      // R11: test port loads and readback
      mem_wr(12'hF80, 8'hC3);
      mem_rd(12'hF80, rd);
      check("R11 mem readback", {8'h0, rd}, 16'h00C3);
      load_w(8'h33);
      check("R11 w load", {8'h0, w_o}, 16'h0033);
      load_bsr(4'h9);
      check("R11 bsr load", {12'h0, bsr_o}, 16'h0009);

      // R1: reset again from loaded state
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R1 w after rerun", {8'h0, w_o}, 16'h0);
      check("R1 bsr after rerun", {12'h0, bsr_o}, 16'h0);
      check("R1 phase after rerun", {14'h0, phase_o}, 16'h0);

      // R3: the worked example
      mem_wr(12'h010, 8'hD7);
      exec(16'h4010);
      check("R3 example 0xD7", {8'h0, w_o}, 16'h00EB);

      // R3, R4, R6: all operands, result to working register
      load_bsr(4'h1);
      for (int v = 0; v < 256; v++) begin
         mem_wr(12'h100 | 12'(v), 8'(v));
         exec(16'h4100 | 16'(v));
         r = rotr(8'(v));
         check("R3 rotate to w", {8'h0, w_o}, {8'h0, r});
         check("R6 n after rotate", {15'h0, flag_n_o}, {15'h0, r[7]});
         check("R6 z after rotate", {15'h0, flag_z_o}, {15'h0, (r == 8'h00)});
         mem_rd(12'h100 | 12'(v), rd);
         check("R4 file kept when d=0", {8'h0, rd}, 16'(v));
      end

      // R3, R4, R6: all operands, result back to memory
      load_w(8'hA5);
      for (int v = 0; v < 256; v++) begin
         mem_wr(12'h100 | 12'(v), 8'(v));
         exec(16'h4300 | 16'(v));
         r = rotr(8'(v));
         mem_rd(12'h100 | 12'(v), rd);
         check("R3 rotate to file", {8'h0, rd}, {8'h0, r});
         check("R4 w kept when d=1", {8'h0, w_o}, 16'h00A5);
         check("R6 z after file rotate", {15'h0, flag_z_o}, {15'h0, (r == 8'h00)});
      end

      // R5, R6: set, banked mode with BSR=0, every field value
      load_bsr(4'h0);
      load_w(8'h5C);
      for (int f = 0; f < 256; f++) begin
         n0 = flag_n_o; z0 = flag_z_o;
         mem_wr(12'(f), 8'h5A);
         exec(16'h6900 | 16'(f));
         mem_rd(12'(f), rd);
         check("R5 set value", {8'h0, rd}, 16'h00FF);
         check("R5 w kept on set", {8'h0, w_o}, 16'h005C);
         check("R6 flags kept on set", {14'h0, flag_n_o, flag_z_o}, {14'h0, n0, z0});
      end

      // R7: direct mode ignores BSR
      load_bsr(4'h1);
      for (int f = 0; f < 256; f++) begin
         ea = (f < 128) ? 12'(f) : (12'hF00 | 12'(f));
         alias_a = 12'h100 | 12'(f);
         mem_wr(ea, 8'h22);
         mem_wr(alias_a, 8'h33);
         exec(16'h6800 | 16'(f));
         mem_rd(ea, rd);
         check("R7 direct target", {8'h0, rd}, 16'h00FF);
         mem_rd(alias_a, rd);
         check("R7 banked alias untouched", {8'h0, rd}, 16'h0033);
      end

      // R8, R10: banked mode across every BSR value
      mem_wr(12'h03C, 8'h11);
      mem_wr(12'h13C, 8'h11);
      mem_wr(12'hF3C, 8'h11);
      for (int b = 0; b < 16; b++) begin
         load_bsr(4'(b));
         exec(16'h693C);
         mem_rd({4'(b), 8'h3C}, rd);
         check(stored({4'(b), 8'h3C}) ? "R8 banked target" : "R10 unstored bank reads 0",
               {8'h0, rd}, stored({4'(b), 8'h3C}) ? 16'h00FF : 16'h0000);
         mem_rd(12'h13C, rd);
         check("R8 bank 1 copy", {8'h0, rd}, (b >= 1) ? 16'h00FF : 16'h0011);
         mem_rd(12'hF3C, rd);
         check("R8 top bank copy", {8'h0, rd}, (b >= 15) ? 16'h00FF : 16'h0011);
      end

      // R10: rotate from an unstored bank
      load_bsr(4'h7);
      load_w(8'h77);
      exec(16'h4120);
      check("R10 unstored rotate to w", {8'h0, w_o}, 16'h0000);
      check("R10 unstored rotate flags", {14'h0, flag_n_o, flag_z_o}, 16'h0001);

      // R9: every unrecognised upper byte
      load_bsr(4'h0);
      mem_wr(12'h005, 8'h96);
      load_w(8'h3C);
      for (int hi = 0; hi < 256; hi++) begin
         if ((hi >= 8'h40 && hi <= 8'h43) || hi == 8'h68 || hi == 8'h69) continue;
         n0 = flag_n_o; z0 = flag_z_o;
         exec({8'(hi), 8'h05});
         check("R9 w unchanged", {8'h0, w_o}, 16'h003C);
         check("R9 flags unchanged", {14'h0, flag_n_o, flag_z_o}, {14'h0, n0, z0});
         mem_rd(12'h005, rd);
         check("R9 memory unchanged", {8'h0, rd}, 16'h0096);
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (180000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule